// File: doc/BRIEF.md
# Phase-shifted full-bridge PWM generator

This block drives the four switches of a full bridge: a high-side PMOS and a low-side NMOS in each of two legs. A free-running 7-bit phase counter spans one carrier period of 128 clocks. From it the block forms four triangular carriers that sit a quarter period apart. Each leg picks one carrier and compares it with its own 6-bit duty input. This gives a raw PWM whose high time is twice the duty value, in clocks. The leg then turns that raw PWM into a complementary pair of gate commands. Each turn-on in the pair is held back by a programmable dead time.

The block has no register interface. Configuration arrives as an 11-bit word on a slow serial pair, a strobe and a data line, which are sampled by the system clock. The word holds the dead time, the two carrier selectors and the output mode. Shifted bits collect in a holding register. They become active only at the end of a carrier period, and only once a whole word has been received, so a running bridge never sees a half-written setting. An enable input and a registered output stage set the final pins. A fifth output mirrors the clock.

Top module: `psfb_pwm`

## Requirements
- R1: A 7-bit phase counter counts 0 to 127 and wraps, one step per clock. Carrier k (k = 0..3) equals tri((phase + 32k) mod 128). Here tri(x) = x for x < 64 and 127 - x otherwise, so each carrier runs 0 up to 63 and back down.
- R2: A leg's raw PWM is high while its duty is greater than the selected carrier. With dead time 0, in normal mode the leg's high-side gate is high for exactly 2*d clocks of every 128 (0 for d = 0, 126 for d = 63).
- R3: The 2-bit selector value k of a leg picks carrier k. With leg A on carrier 0 and leg B on carrier k, and equal duties, leg A's high-side rising edge comes 32k clocks (mod 128) after leg B's.
- R4: Dead time dt (0..31) delays each high-side turn-on until dt clocks after the raw PWM rises. It delays each low-side turn-on until dt clocks after the raw PWM falls. Per period the high side is on for max(0, 2d - dt) clocks. The low side is on for max(0, 128 - 2d - dt) clocks, or all 128 when d = 0.
- R5: The high-side and low-side gates of one leg are never high in the same cycle, in any mode.
- R6: Each rising edge of cfgClk, as seen by clk, shifts cfgData into an 11-bit holding register. The first bit sent lands in bit 0. Word layout: bits 4:0 dead time (bit 0 sent first), bits 6:5 leg A selector, bits 8:7 leg B selector, bits 10:9 output mode.
- R7: The holding register is copied into the active configuration only in the cycle where the phase is 127, and only if 11 bits have been shifted since the previous copy. A new setting first reaches the pins at phase 1 of the next period, 31 clocks after the rise of a 50 % high-side pulse on carrier 0.
- R8: Output mode 00 is normal operation. 01 drives all four gates low. 10 passes each raw PWM to its high side and its complement to its low side, with no dead time. 11 exchanges the two legs on the pins.
- R9: Pin mapping: gates[0] = leg A high side (PMOS1), gates[1] = leg B low side (NMOS2), gates[2] = leg B high side (PMOS2), gates[3] = leg A low side (NMOS1).
- R10: gates is registered. If enable is low at a clock edge, all four gates are low after that edge.
- R11: An active-low asynchronous reset clears gates, the phase counter and both configuration registers. The active setting after reset is dead time 0, both selectors 0, normal mode.
- R12: clkMirror is a copy of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one carrier step per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Gate enable; low forces all gates low |
| dutyA | input | 6 | Leg A duty, fraction dutyA/64 |
| dutyB | input | 6 | Leg B duty, fraction dutyB/64 |
| cfgClk | input | 1 | Serial configuration strobe, rising edge shifts |
| cfgData | input | 1 | Serial configuration data |
| gates | output | 4 | Gate commands {NMOS1, PMOS2, NMOS2, PMOS1} |
| clkMirror | output | 1 | Copy of clk |

## Verification
The bench sweeps every duty value under three settings: zero dead time, a non-zero dead time, and raw mode. For each it counts the on-time of every pin over a full period. An off-by-one in the compare, a dead-time counter that delays the wrong edge, or one that stops at the wrong value shows up as a wrong count, most sharply at duty 0 and 63. The four selector values are checked by measuring the distance between the legs' rising edges, which catches a swapped or mis-scaled carrier offset. The commit point is timed against a known pulse edge, so a copy made mid-period is seen. A 5-bit partial word must leave the outputs alone, which catches a design that commits half-shifted words. Swap, off and enable modes are checked pin by pin, so a crossed pin mapping is exposed.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DutyW   = 6;
  localparam int DtW     = 5;
  localparam int SelW    = 2;
  localparam int PhaseW  = DutyW + 1;
  localparam int Carriers = 1 << SelW;
  localparam int GateN   = 4;

  typedef enum logic [1:0] {
    ModeNormal = 2'b00,
    ModeOff    = 2'b01,
    ModeRaw    = 2'b10,
    ModeSwap   = 2'b11
  } outMode_t;

  typedef struct packed {
    outMode_t              mode;
    logic [SelW-1:0]       selB;
    logic [SelW-1:0]       selA;
    logic [DtW-1:0]        dt;
  } pwmCfg_t;

  localparam int CfgW = $bits(pwmCfg_t);

  typedef struct packed {
    logic [PhaseW-1:0] phase;
    pwmCfg_t           cfg;
  } ctrlBus_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgClk,
  input  logic     cfgData,
  output ctrlBus_t bus
);
  localparam int CntW = $clog2(CfgW + 1);
  localparam logic [CntW-1:0] CntFull = CntW'(CfgW);
  localparam logic [CntW-1:0] CntOne  = CntW'(1);

  logic [2:0]        clkSync;
  logic [1:0]        dataSync;
  logic              shiftStb;
  logic [CfgW-1:0]   holdReg;
  logic [CntW-1:0]   bitCnt;
  logic [PhaseW-1:0] phase;
  logic              periodEnd;
  logic              commitStb;
  pwmCfg_t           activeCfg;

  // Bring the slow strobe and data into the clk domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
    end else begin
      clkSync  <= {clkSync[1:0], cfgClk};
      dataSync <= {dataSync[0], cfgData};
    end
  end

  assign shiftStb  = clkSync[1] & ~clkSync[2];
  assign periodEnd = (phase == {PhaseW{1'b1}});
  assign commitStb = periodEnd && (bitCnt == CntFull);

  // Holding register: first bit ends up in bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      bitCnt  <= '0;
    end else begin
      if (shiftStb)
        holdReg <= {dataSync[1], holdReg[CfgW-1:1]};
      if (commitStb)
        bitCnt <= shiftStb ? CntOne : '0;
      else if (shiftStb && bitCnt != CntFull)
        bitCnt <= bitCnt + CntOne;
    end
  end

  // Free-running carrier phase and period-aligned commit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      activeCfg <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (commitStb)
        activeCfg <= pwmCfg_t'(holdReg);
    end
  end

  always_comb begin
    bus.phase = phase;
    bus.cfg   = activeCfg;
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           rawNext,
  input  logic [DtW-1:0] dt,
  output logic           raw,
  output logic           hi,
  output logic           lo
);
  localparam logic [DtW-1:0] AgeMax = {DtW{1'b1}};

  // age: clocks since raw took its present level, saturating.
  logic [DtW-1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      raw <= 1'b0;
      age <= '0;
    end else begin
      raw <= rawNext;
      if (rawNext != raw)
        age <= '0;
      else if (age != AgeMax)
        age <= age + 1'b1;
    end
  end

  assign hi = raw  && (age >= dt);
  assign lo = !raw && (age >= dt);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DutyW-1:0] dutyA,
  input  logic [DutyW-1:0] dutyB,
  input  ctrlBus_t         bus,
  output logic [GateN-1:0] gates
);
  localparam int Quarter = (1 << PhaseW) / Carriers;
  localparam int Legs    = 2;

  logic [DutyW-1:0] carrier [Carriers];
  logic [DutyW-1:0] legDuty [Legs];
  logic [SelW-1:0]  legSel  [Legs];
  logic [Legs-1:0]  legRaw;
  logic [Legs-1:0]  legHi;
  logic [Legs-1:0]  legLo;

  // Quarter-shifted triangle carriers folded from the phase counter.
  for (genvar k = 0; k < Carriers; k++) begin : g_car
    logic [PhaseW-1:0] shifted;
    assign shifted    = bus.phase + PhaseW'(k * Quarter);
    assign carrier[k] = shifted[PhaseW-1] ? ~shifted[DutyW-1:0] : shifted[DutyW-1:0];
  end

  assign legDuty[0] = dutyA;
  assign legDuty[1] = dutyB;
  assign legSel[0]  = bus.cfg.selA;
  assign legSel[1]  = bus.cfg.selB;

  for (genvar g = 0; g < Legs; g++) begin : g_leg
    logic rawNext;
    assign rawNext = legDuty[g] > carrier[legSel[g]];
    pwm_deadband u_db (
      .clk     (clk),
      .rstN    (rstN),
      .rawNext (rawNext),
      .dt      (bus.cfg.dt),
      .raw     (legRaw[g]),
      .hi      (legHi[g]),
      .lo      (legLo[g])
    );
  end

  logic pA, nA, pB, nB;
  always_comb begin
    pA = 1'b0; nA = 1'b0; pB = 1'b0; nB = 1'b0;
    unique case (bus.cfg.mode)
      ModeNormal: begin
        pA = legHi[0]; nA = legLo[0]; pB = legHi[1]; nB = legLo[1];
      end
      ModeOff: ;
      ModeRaw: begin
        pA = legRaw[0]; nA = ~legRaw[0]; pB = legRaw[1]; nB = ~legRaw[1];
      end
      ModeSwap: begin
        pA = legHi[1]; nA = legLo[1]; pB = legHi[0]; nB = legLo[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gates <= '0;
    else if (enable)
      gates <= {nA, pB, nB, pA};
    else
      gates <= '0;
  end
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DutyW-1:0] dutyA,
  input  logic [DutyW-1:0] dutyB,
  input  logic             cfgClk,
  input  logic             cfgData,
  output logic [GateN-1:0] gates,
  output logic             clkMirror
);
  ctrlBus_t ctrlBus;

  pwm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgClk  (cfgClk),
    .cfgData (cfgData),
    .bus     (ctrlBus)
  );

  pwm_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .dutyA  (dutyA),
    .dutyB  (dutyB),
    .bus    (ctrlBus),
    .gates  (gates)
  );

  assign clkMirror = clk;
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int PhaseW = 7,
  parameter int CfgW   = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [3:0]        gates,
  input logic [PhaseW-1:0] phase,
  input logic [CfgW-1:0]   cfgBits,
  input logic [1:0]        mode
);
  p_no_shoot_r5: assert property (@(posedge clk) disable iff (!rstN)
    !((gates[0] && gates[3]) || (gates[2] && gates[1])));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> phase == PhaseW'($past(phase) + 1'b1));

  p_commit_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgBits) |-> $past(phase) == {PhaseW{1'b1}});

  p_enable_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> gates == 4'b0000);

  p_force_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |=> gates == 4'b0000);

  p_raw_comp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && enable) |=> (gates[3] == !gates[0]) && (gates[1] == !gates[2]));
endmodule

bind psfb_pwm pwm_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .gates   (gates),
  .phase   (ctrlBus.phase),
  .cfgBits (ctrlBus.cfg),
  .mode    (ctrlBus.cfg.mode)
);

// File: tb/tb_psfb_pwm.sv
module tb_psfb_pwm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] dutyA = '0;
  logic [5:0] dutyB = '0;
  logic       cfgClk = 1'b0;
  logic       cfgData = 1'b0;
  logic [3:0] gates;
  logic       clkMirror;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastRiseP1 = -1;
  logic prevP1 = 1'b0;
  int cP1, cN2, cP2, cN1, rA, rB;

  psfb_pwm dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dutyA(dutyA), .dutyB(dutyB),
    .cfgClk(cfgClk), .cfgData(cfgData), .gates(gates), .clkMirror(clkMirror)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (gates[0] && !prevP1) lastRiseP1 = cyc;
    prevP1 = gates[0];
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expHi(int d, int dt, bit rawMode);
    int len = 2 * d;
    if (rawMode) return len;
    return (len > dt) ? len - dt : 0;
  endfunction

  function automatic int expLo(int d, int dt, bit rawMode);
    int len = 128 - 2 * d;
    if (rawMode || d == 0) return len;
    return (len > dt) ? len - dt : 0;
  endfunction

  task automatic shiftBit(input logic b);
    cfgData = b;
    repeat (3) @(negedge clk);
    cfgClk = 1'b1;
    repeat (3) @(negedge clk);
    cfgClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic loadCfg(input int dt, input int sA, input int sB, input int md);
    logic [10:0] w;
    w = {md[1:0], sB[1:0], sA[1:0], dt[4:0]};
    for (int i = 0; i < 11; i++) shiftBit(w[i]);
    repeat (300) @(negedge clk);
  endtask

  task automatic measure();
    logic pa, pb;
    cP1 = 0; cN2 = 0; cP2 = 0; cN1 = 0; rA = -1; rB = -1;
    @(negedge clk);
    pa = gates[0]; pb = gates[2];
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      cP1 += gates[0]; cN2 += gates[1]; cP2 += gates[2]; cN1 += gates[3];
      if (gates[0] && !pa) rA = i;
      if (gates[2] && !pb) rB = i;
      pa = gates[0]; pb = gates[2];
    end
  endtask

  task automatic sweep(input int dt, input bit rawMode, input string tag);
    for (int d = 0; d < 64; d++) begin
      dutyA = 6'(d);
      dutyB = 6'(63 - d);
      repeat (200) @(negedge clk);
      measure();
      chk($sformatf("%s PMOS1 d=%0d", tag, d), cP1, expHi(d, dt, rawMode));
      chk($sformatf("%s NMOS1 d=%0d", tag, d), cN1, expLo(d, dt, rawMode));
      chk($sformatf("%s PMOS2 d=%0d", tag, 63 - d), cP2, expHi(63 - d, dt, rawMode));
      chk($sformatf("%s NMOS2 d=%0d", tag, 63 - d), cN2, expLo(63 - d, dt, rawMode));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tOff;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 gates in reset", int'(gates), 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 default normal, duty 0 -> lows on", int'(gates), 4'b1010);

    // R12: clock mirror
    chk("R12 mirror low phase", int'(clkMirror), 0);
    @(posedge clk); #1;
    chk("R12 mirror high phase", int'(clkMirror), 1);

    // R2 R4 R9: default config, dt 0, every duty
    sweep(0, 1'b0, "R2 R9 dt0");

    // R4 R6: dead time 5, selectors 1 and 3
    loadCfg(5, 1, 3, 0);
    sweep(5, 1'b0, "R4 R6 dt5");

    // R3 R1: carrier offset per selector
    for (int k = 0; k < 4; k++) begin
      loadCfg(0, 0, k, 0);
      dutyA = 6'd20; dutyB = 6'd20;
      repeat (200) @(negedge clk);
      measure();
      chk($sformatf("R3 R1 edge distance sel=%0d", k), (rA - rB + 256) % 128, (32 * k) % 128);
    end

    // R7: commit timing, new mode reaches pins at phase 1
    loadCfg(0, 0, 0, 0);
    dutyA = 6'd32; dutyB = 6'd32;
    repeat (300) @(negedge clk);
    for (int i = 0; i < 11; i++) shiftBit((i == 9) ? 1'b1 : 1'b0);
    tOff = -1;
    for (int i = 0; i < 300 && tOff < 0; i++) begin
      @(negedge clk);
      if (gates == 4'b0000) tOff = cyc;
    end
    chk("R7 commit offset from PMOS1 rise", (tOff - lastRiseP1 + 1280) % 128, 31);

    // R8: off mode
    repeat (300) @(negedge clk);
    measure();
    chk("R8 off PMOS1", cP1, 0);
    chk("R8 off NMOS1", cN1, 0);
    chk("R8 off PMOS2", cP2, 0);
    chk("R8 off NMOS2", cN2, 0);

    // R7 R6: partial word is not committed
    loadCfg(0, 0, 0, 0);
    dutyA = 6'd20; dutyB = 6'd20;
    for (int i = 0; i < 5; i++) shiftBit(1'b1);
    repeat (400) @(negedge clk);
    measure();
    chk("R7 partial word ignored PMOS1", cP1, 40);
    chk("R7 partial word ignored NMOS1", cN1, 88);
    for (int i = 0; i < 6; i++) shiftBit(1'b0);
    repeat (300) @(negedge clk);
    measure();
    chk("R6 completed word dt31 PMOS1", cP1, 9);
    chk("R6 completed word dt31 NMOS1", cN1, 57);

    // R8 R9: swap legs
    loadCfg(0, 0, 0, 3);
    dutyA = 6'd10; dutyB = 6'd40;
    repeat (200) @(negedge clk);
    measure();
    chk("R8 R9 swap PMOS1 carries leg B", cP1, 80);
    chk("R8 R9 swap NMOS1 carries leg B", cN1, 48);
    chk("R8 R9 swap PMOS2 carries leg A", cP2, 20);
    chk("R8 R9 swap NMOS2 carries leg A", cN2, 108);

    // R8: raw mode ignores dead time 9
    loadCfg(9, 2, 1, 2);
    sweep(9, 1'b1, "R8 raw");

    // R10: enable
    loadCfg(0, 0, 0, 0);
    dutyA = 6'd20; dutyB = 6'd20;
    repeat (200) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 gates low one edge after enable drop", int'(gates), 0);
    repeat (20) @(negedge clk);
    chk("R10 gates stay low", int'(gates), 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 gates resume (one of each leg on)", int'(gates[0] | gates[3]) + int'(gates[1] | gates[2]), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule